// File: doc/BRIEF.md
# Power Management Control and Status Register

This block is one 16-bit control/status word that a bus-attached peripheral exposes to software for power management. Software writes through a plain write strobe with two byte-lane enables and reads the whole word back combinationally. A two-bit power state field selects between full operation, a low-power state and an off state. The block turns that field into registered enables for the DMA contexts, the link layer and the link power status signal. In the off state it also raises a flag that says power may be removed.

The word also holds a wake-event enable bit and a sticky wake-event status bit. While the device is in either low-power state, a link-on indication from the physical layer sets the status bit. Software clears the status bit by writing a one to it. A registered request output goes high when both the status bit and the enable bit are set.

Top module: `pm_csr_reg`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) sets the state field to 00, the wake enable bit to 0 and the wake status bit to 0. After reset, `dma_ctx_en`, `link_layer_en` and `link_pwr_en` are 1, and `pwr_removable` and `wake_req` are 0.
- R2: A write with `wr_be[0]` high and `wr_data[1:0]` equal to 00, 10 or 11 stores that value in the state field, which reads back at `rd_data[1:0]`. The codes are 00 = full power, 10 = low power and 11 = off.
- R3: A write of 01 to the state field is dropped, and the field keeps its previous value.
- R4: One clock after the state field changes, the outputs follow it. With state 00, `dma_ctx_en`, `link_layer_en` and `link_pwr_en` are 1. With 10 or 11, all three are 0. `pwr_removable` is 1 only with 11.
- R5: The wake enable bit is `rd_data[8]`. A write with `wr_be[1]` high loads it from `wr_data[8]`.
- R6: Bits 7:2 and 14:9 always read as 0, and writing ones to them has no effect.
- R7: If `link_on` is high at a clock edge while the state field is 10 or 11, the wake status bit `rd_data[15]` is 1 after that edge. In state 00, `link_on` does not set it.
- R8: The wake status bit is sticky. A write with `wr_be[1]` high and `wr_data[15]`=1 clears it, and a write of 0 leaves it unchanged. If a set event and a clear arrive in the same cycle, the bit ends up set.
- R9: `wake_req` is 1 one clock after a cycle in which both the wake status bit and the wake enable bit are 1, and 0 otherwise.
- R10: A byte lane whose enable is low is not written. `wr_be[0]` covers bits 7:0 and `wr_be[1]` covers bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 2 | Byte-lane enables (bit 0 = bits 7:0, bit 1 = bits 15:8) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register contents |
| link_on | input | 1 | Link-on indication from the physical layer |
| dma_ctx_en | output | 1 | DMA context enable |
| link_layer_en | output | 1 | Link layer enable |
| link_pwr_en | output | 1 | Link power status signal |
| pwr_removable | output | 1 | Power may be removed (off state) |
| wake_req | output | 1 | Registered wake-event request |

## Verification
The hardest case to reach is a software clear of the wake status bit in the same cycle as a link-on event while the device is in a low-power state. The stimulus first moves to the low-power state and sets the bit. It then drives a write-one-to-clear together with `link_on` to show that the set wins, and only after that clears the bit on its own. The dropped 01 write and the one-cycle lag of the enables are checked in the cycle right after each state write.

// File: rtl/pm_csr_pkg.sv
package pm_csr_pkg;

    localparam int REG_W      = 16;
    localparam int LANE_W     = 8;
    localparam int NUM_LANES  = REG_W / LANE_W;
    localparam int STATE_W    = 2;
    localparam int STATE_LSB  = 0;
    localparam int WAKE_EN_B  = 8;
    localparam int WAKE_ST_B  = 15;

    typedef enum logic [STATE_W-1:0] {
        PWR_FULL = 2'b00,
        PWR_RSVD = 2'b01,
        PWR_LOW  = 2'b10,
        PWR_OFF  = 2'b11
    } pwr_state_e;

    typedef struct packed {
        logic dma;
        logic link;
        logic lps;
        logic cut;
    } pwr_ctl_t;

    function automatic pwr_ctl_t decode_state(pwr_state_e s);
        pwr_ctl_t c;
        c.dma  = (s == PWR_FULL);
        c.link = (s == PWR_FULL);
        c.lps  = (s == PWR_FULL);
        c.cut  = (s == PWR_OFF);
        return c;
    endfunction

    function automatic logic is_low_power(pwr_state_e s);
        return (s == PWR_LOW) || (s == PWR_OFF);
    endfunction

    function automatic logic state_accepted(logic [STATE_W-1:0] v);
        return v != PWR_RSVD;
    endfunction

    function automatic int lane_of(int bit_idx);
        return bit_idx / LANE_W;
    endfunction

endpackage

// File: rtl/pm_state_field.sv
module pm_state_field
    import pm_csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stb,
    input  logic [STATE_W-1:0]  wr_val,
    output pwr_state_e          state_o,
    output pwr_ctl_t            ctl_o
);
    pwr_state_e state_q;
    pwr_ctl_t   ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PWR_FULL;
            ctl_q   <= decode_state(PWR_FULL);
        end else begin
            if (wr_stb && state_accepted(wr_val))
                state_q <= pwr_state_e'(wr_val);
            ctl_q <= decode_state(state_q);
        end
    end

    assign state_o = state_q;
    assign ctl_o   = ctl_q;
endmodule

// File: rtl/pm_wake_event.sv
module pm_wake_event (
    input  logic clk,
    input  logic rst,
    input  logic en_stb,
    input  logic en_val,
    input  logic clr_req,
    input  logic link_on,
    input  logic low_power,
    output logic wake_en_o,
    output logic wake_st_o,
    output logic wake_req_o
);
    logic en_q, st_q, req_q;
    logic set_evt;

    assign set_evt = link_on && low_power;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            st_q  <= 1'b0;
            req_q <= 1'b0;
        end else begin
            if (en_stb)
                en_q <= en_val;
            if (set_evt)
                st_q <= 1'b1;
            else if (clr_req)
                st_q <= 1'b0;
            req_q <= st_q && en_q;
        end
    end

    assign wake_en_o  = en_q;
    assign wake_st_o  = st_q;
    assign wake_req_o = req_q;
endmodule

// File: rtl/pm_read_assemble.sv
module pm_read_assemble
    import pm_csr_pkg::*;
(
    input  pwr_state_e        state,
    input  logic              wake_en,
    input  logic              wake_st,
    output logic [REG_W-1:0]  rd_word
);
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (b >= STATE_LSB && b < STATE_LSB + STATE_W) begin : g_state
            assign rd_word[b] = state[b - STATE_LSB];
        end else if (b == WAKE_EN_B) begin : g_en
            assign rd_word[b] = wake_en;
        end else if (b == WAKE_ST_B) begin : g_st
            assign rd_word[b] = wake_st;
        end else begin : g_zero
            assign rd_word[b] = 1'b0;
        end
    end
endmodule

// File: rtl/pm_csr_reg.sv
module pm_csr_reg
    import pm_csr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [NUM_LANES-1:0]  wr_be,
    input  logic [REG_W-1:0]      wr_data,
    output logic [REG_W-1:0]      rd_data,
    input  logic                  link_on,
    output logic                  dma_ctx_en,
    output logic                  link_layer_en,
    output logic                  link_pwr_en,
    output logic                  pwr_removable,
    output logic                  wake_req
);
    logic [NUM_LANES-1:0] lane_we;
    pwr_state_e           state;
    pwr_ctl_t             ctl;
    logic                 wake_en, wake_st;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign lane_we[l] = wr_en && wr_be[l];
    end

    pm_state_field u_state (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (lane_we[lane_of(STATE_LSB)]),
        .wr_val  (wr_data[STATE_LSB +: STATE_W]),
        .state_o (state),
        .ctl_o   (ctl)
    );

    pm_wake_event u_wake (
        .clk        (clk),
        .rst        (rst),
        .en_stb     (lane_we[lane_of(WAKE_EN_B)]),
        .en_val     (wr_data[WAKE_EN_B]),
        .clr_req    (lane_we[lane_of(WAKE_ST_B)] && wr_data[WAKE_ST_B]),
        .link_on    (link_on),
        .low_power  (is_low_power(state)),
        .wake_en_o  (wake_en),
        .wake_st_o  (wake_st),
        .wake_req_o (wake_req)
    );

    pm_read_assemble u_rd (
        .state   (state),
        .wake_en (wake_en),
        .wake_st (wake_st),
        .rd_word (rd_data)
    );

    assign dma_ctx_en    = ctl.dma;
    assign link_layer_en = ctl.link;
    assign link_pwr_en   = ctl.lps;
    assign pwr_removable = ctl.cut;
endmodule

// File: rtl/pm_csr_checker.sv
module pm_csr_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_be,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        link_on,
    input logic        dma_ctx_en,
    input logic        link_layer_en,
    input logic        link_pwr_en,
    input logic        pwr_removable,
    input logic        wake_req
);
    p_no_rsvd_state_r3: assert property (@(posedge clk) disable iff (rst)
        rd_data[1:0] != 2'b01);

    p_rsvd_write_dropped_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_be[0] && wr_data[1:0] == 2'b01) |=> $stable(rd_data[1:0]));

    p_enables_lag_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (dma_ctx_en == ($past(rd_data[1:0]) == 2'b00))
              && (link_layer_en == dma_ctx_en) && (link_pwr_en == dma_ctx_en));

    p_removable_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pwr_removable == ($past(rd_data[1:0]) == 2'b11)));

    p_zero_bits_r6: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:2] == 6'd0 && rd_data[14:9] == 6'd0);

    p_wake_set_r7: assert property (@(posedge clk) disable iff (rst)
        (link_on && rd_data[1]) |=> rd_data[15]);

    p_wake_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_data[15] && !(wr_en && wr_be[1] && wr_data[15])) |=> rd_data[15]);

    p_req_registered_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wake_req == ($past(rd_data[15]) && $past(rd_data[8]))));
endmodule

bind pm_csr_reg pm_csr_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .link_on(link_on), .dma_ctx_en(dma_ctx_en),
    .link_layer_en(link_layer_en), .link_pwr_en(link_pwr_en),
    .pwr_removable(pwr_removable), .wake_req(wake_req)
);

// File: tb/tb_pm_csr_reg.sv
module tb_pm_csr_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0000;
    logic        link_on = 1'b0;
    logic [15:0] rd_data;
    logic        dma_ctx_en, link_layer_en, link_pwr_en, pwr_removable, wake_req;

    always #2.5 clk = ~clk;

    pm_csr_reg dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_data(rd_data), .link_on(link_on), .dma_ctx_en(dma_ctx_en),
        .link_layer_en(link_layer_en), .link_pwr_en(link_pwr_en),
        .pwr_removable(pwr_removable), .wake_req(wake_req)
    );

    typedef struct {
        string       tag;
        logic [20:0] exp;
    } item_t;

    item_t sb[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;

    // reference state, built from the requirements
    logic [1:0] m_state;
    logic       m_en, m_st, m_on, m_cut, m_req;

    function automatic logic [20:0] model_vec();
        logic [15:0] r;
        r = {m_st, 6'd0, m_en, 6'd0, m_state};
        return {r, m_on, m_on, m_on, m_cut, m_req};
    endfunction

    // monitor: pops one expectation per falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [20:0] act;
            it  = sb.pop_front();
            act = {rd_data, dma_ctx_en, link_layer_en, link_pwr_en, pwr_removable, wake_req};
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    // driver: one cycle of stimulus, then queue the predicted outcome
    task automatic cyc(input string tag, input logic we, input logic [1:0] be,
                       input logic [15:0] d, input logic lon);
        logic [1:0] n_state;
        logic       n_en, n_st;
        @(negedge clk);
        wr_en = we; wr_be = be; wr_data = d; link_on = lon;
        @(posedge clk);
        n_state = (we && be[0] && d[1:0] != 2'b01) ? d[1:0] : m_state;
        n_en    = (we && be[1]) ? d[8] : m_en;
        if (lon && m_state[1])         n_st = 1'b1;
        else if (we && be[1] && d[15]) n_st = 1'b0;
        else                           n_st = m_st;
        m_req   = m_st && m_en;
        m_on    = (m_state == 2'b00);
        m_cut   = (m_state == 2'b11);
        m_state = n_state; m_en = n_en; m_st = n_st;
        sb.push_back('{tag, model_vec()});
    endtask

    initial begin
        m_state = 2'b00; m_en = 1'b0; m_st = 1'b0; m_on = 1'b1; m_cut = 1'b0; m_req = 1'b0;
        repeat (3) @(posedge clk);
        sb.push_back('{"R1 reset values", model_vec()});
        @(negedge clk); rst = 1'b0;
        cyc("R1 idle after reset",              0, 2'b00, 16'h0000, 0);
        cyc("R5 set wake enable",               1, 2'b10, 16'h0100, 0);
        cyc("R2 write low power",               1, 2'b01, 16'h0002, 0);
        cyc("R4 enables drop one cycle later",  0, 2'b00, 16'h0000, 0);
        cyc("R3 reserved code dropped",         1, 2'b01, 16'h0001, 0);
        cyc("R3 state kept",                    0, 2'b00, 16'h0000, 0);
        cyc("R7 link-on in low power sets",     0, 2'b00, 16'h0000, 1);
        cyc("R9 request follows",               0, 2'b00, 16'h0000, 0);
        cyc("R8 write zero keeps status",       1, 2'b10, 16'h0100, 0);
        cyc("R8 set wins over clear",           1, 2'b10, 16'h8100, 1);
        cyc("R8 clear by write one",            1, 2'b10, 16'h8100, 0);
        cyc("R9 request falls",                 0, 2'b00, 16'h0000, 0);
        cyc("R6 write ones to constant bits",   1, 2'b01, 16'hFFFF, 0);
        cyc("R4 off state removable flag",      0, 2'b00, 16'h0000, 0);
        cyc("R10 no lanes enabled",             1, 2'b00, 16'h0000, 0);
        cyc("R10 upper lane only keeps state",  1, 2'b10, 16'h00FD, 0);
        cyc("R5 clear wake enable",             1, 2'b10, 16'h0000, 0);
        cyc("R7 link-on in off state",          0, 2'b00, 16'h0000, 1);
        cyc("R9 no request without enable",     0, 2'b00, 16'h0000, 0);
        cyc("R2 back to full power",            1, 2'b01, 16'h0000, 0);
        cyc("R4 enables return",                1, 2'b10, 16'h8000, 0);
        cyc("R7 link-on in full power ignored", 0, 2'b00, 16'h0000, 1);
        cyc("R6 upper constant bits ignored",   1, 2'b10, 16'h7E00, 0);
        cyc("R10 lower lane only keeps enable", 1, 2'b01, 16'h0003, 0);
        cyc("R4 off after lane write",          0, 2'b00, 16'h0000, 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule